// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This unit takes one memory request from a 32-thread warp and turns it into a sequence of 128-byte cache-line transactions toward the first-level cache. Each thread supplies a byte address. An active mask marks the threads that take part. One access size and a load/store flag apply to the whole request. Threads whose accesses land in the same line are merged into one transaction, and repeated addresses collapse. The exception is 16-byte accesses: there, one transaction may carry at most 16 threads.

The unit works on one request at a time. It emits one transaction per handshake on a valid/ready output. Each transaction carries the line-aligned address and a 128-bit byte-enable mask. When the last transaction has been taken, a single-cycle done pulse reports how many transactions were issued. A request that is misaligned, or that has an unsupported size code, issues nothing and completes with an error flag.

Top module: `warp_coalescer`

## Requirements
- R1: After reset the unit is idle: `req_ready_o` is 1, `txn_valid_o` is 0 and `done_o` is 0.
- R2: Size code `req_size_i` 0,1,2,3,4 selects 1,2,4,8,16 bytes per thread. Every transaction address has its low 7 bits zero. Byte k of `txn_be_o` is set exactly when some thread served by that transaction covers line offset k.
- R3: When every active thread targets a different line, the transaction count equals the number of active threads.
- R4: Active threads within one line (at most the per-transaction cap) are served by one transaction, and identical addresses collapse into the same enabled bytes.
- R5: With 16-byte accesses, one transaction serves at most 16 threads. A full warp storing 16 bytes to one address yields exactly 2 transactions.
- R6: Threads whose mask bit is 0 cause no transaction, no enabled byte and no error, whatever their address.
- R7: Each transaction takes the line of the lowest-numbered active thread not yet served, then serves the eligible threads of that line in ascending thread order.
- R8: If an active thread's address is not a multiple of the access size, or the size code is 5 to 7, no transaction is issued and done pulses with `done_err_o` 1 and a count of 0.
- R9: An all-zero active mask completes with done, a count of 0, no error and no transaction.
- R10: A request is taken only while `req_ready_o` is 1. Once a request is taken, `req_ready_o` stays 0 up to and including the done cycle.
- R11: While `txn_valid_o` is 1 and `txn_ready_i` is 0, the transaction address and byte mask hold stable.
- R12: `done_o` pulses for one cycle, in the cycle after the last handshake, and `done_count_o` equals the number of handshakes. `txn_store_o` repeats the request's store flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Unit idle, request can be taken |
| req_addr_i | input | THREADS*ADDR_W | Per-thread byte addresses, thread i at bits i*ADDR_W upward |
| req_mask_i | input | THREADS | Active thread mask |
| req_size_i | input | 3 | Access size code |
| req_store_i | input | 1 | 1 = store, 0 = load |
| txn_valid_o | output | 1 | Transaction available |
| txn_ready_i | input | 1 | Transaction taken |
| txn_addr_o | output | ADDR_W | Line-aligned transaction address |
| txn_be_o | output | LINE_BYTES | Byte enables within the line |
| txn_store_o | output | 1 | Store flag of the transaction |
| done_o | output | 1 | Request completed (one cycle) |
| done_count_o | output | $clog2(THREADS+1) | Transactions issued for the request |
| done_err_o | output | 1 | Request rejected as misaligned or unsupported size |

## Verification
The hardest case to reach from the ports is a line that holds more eligible threads than the wide-access cap. The remainder must then come back as a later transaction for the same line, and that transaction has to appear in the correct position between the other lines. Random addresses almost never pile 17 or more threads into one line. So the random stimulus draws addresses from a pool of only two or three lines, which makes such crowding common. Directed requests add a full warp to one 16-byte address and a mixed warp where the overflow of one line is interleaved with other lines, all under random backpressure on the output.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [2:0] {
    SZ_B1  = 3'd0,
    SZ_B2  = 3'd1,
    SZ_B4  = 3'd2,
    SZ_B8  = 3'd3,
    SZ_B16 = 3'd4
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } coal_state_e;
endpackage

// File: rtl/coal_align_check.sv
module coal_align_check #(
  parameter int unsigned THREADS = 32
) (
  input  logic [THREADS-1:0][3:0] low_i,
  input  logic [THREADS-1:0]      mask_i,
  input  logic [2:0]              size_i,
  output logic                    bad_o
);
  import coal_pkg::*;

  logic [THREADS-1:0] mis;
  logic [3:0]         low_mask;
  logic               size_bad;

  assign size_bad = (size_i > 3'(SZ_B16));
  assign low_mask = size_bad ? 4'h0 : 4'((5'd1 << size_i) - 5'd1);

  for (genvar g = 0; g < THREADS; g++) begin : g_thr
    assign mis[g] = mask_i[g] & (|(low_i[g] & low_mask));
  end

  assign bad_o = size_bad | (|mis);
endmodule

// File: rtl/coal_pick.sv
module coal_pick #(
  parameter int unsigned THREADS = 32,
  parameter int unsigned LINE_W  = 25,
  localparam int unsigned IDX_W  = $clog2(THREADS),
  localparam int unsigned CNT_W  = $clog2(THREADS + 1)
) (
  input  logic [THREADS-1:0]             pend_i,
  input  logic [THREADS-1:0][LINE_W-1:0] line_i,
  input  logic [CNT_W-1:0]               cap_i,
  output logic [LINE_W-1:0]              lead_line_o,
  output logic [THREADS-1:0]             serve_o
);
  logic [IDX_W-1:0]   lead_idx;
  logic [THREADS-1:0] elig;
  logic [CNT_W-1:0]   taken;

  // lowest pending thread leads
  always_comb begin
    lead_idx = '0;
    for (int i = THREADS - 1; i >= 0; i--) begin
      if (pend_i[i]) lead_idx = IDX_W'(i);
    end
  end

  assign lead_line_o = line_i[lead_idx];

  for (genvar g = 0; g < THREADS; g++) begin : g_match
    assign elig[g] = pend_i[g] && (line_i[g] == lead_line_o);
  end

  always_comb begin
    taken   = '0;
    serve_o = '0;
    for (int i = 0; i < THREADS; i++) begin
      if (elig[i] && (taken < cap_i)) begin
        serve_o[i] = 1'b1;
        taken      = taken + 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_byte_en.sv
module coal_byte_en #(
  parameter int unsigned THREADS    = 32,
  parameter int unsigned LINE_BYTES = 128,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic [THREADS-1:0]            serve_i,
  input  logic [THREADS-1:0][OFF_W-1:0] off_i,
  input  logic [2:0]                    size_i,
  output logic [LINE_BYTES-1:0]         be_o
);
  logic [4:0]            nbytes;
  logic [15:0]           span16;
  logic [LINE_BYTES-1:0] span;
  logic [LINE_BYTES-1:0] thr_be [THREADS];

  assign nbytes = 5'd1 << size_i;
  assign span16 = 16'((17'd1 << nbytes) - 17'd1);
  assign span   = {{(LINE_BYTES-16){1'b0}}, span16};

  for (genvar g = 0; g < THREADS; g++) begin : g_thr
    assign thr_be[g] = serve_i[g] ? (span << off_i[g]) : '0;
  end

  always_comb begin
    be_o = '0;
    for (int i = 0; i < THREADS; i++) be_o = be_o | thr_be[i];
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int unsigned THREADS    = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned WIDE_CAP   = 16,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = ADDR_W - OFF_W,
  localparam int unsigned CNT_W     = $clog2(THREADS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [THREADS*ADDR_W-1:0] req_addr_i,
  input  logic [THREADS-1:0]        req_mask_i,
  input  logic [2:0]                req_size_i,
  input  logic                      req_store_i,
  output logic                      txn_valid_o,
  input  logic                      txn_ready_i,
  output logic [ADDR_W-1:0]         txn_addr_o,
  output logic [LINE_BYTES-1:0]     txn_be_o,
  output logic                      txn_store_o,
  output logic                      done_o,
  output logic [CNT_W-1:0]          done_count_o,
  output logic                      done_err_o
);
  import coal_pkg::*;

  coal_state_e                     state_q;
  logic [THREADS-1:0][ADDR_W-1:0]  addr_in;
  logic [THREADS-1:0][ADDR_W-1:0]  addr_q;
  logic [THREADS-1:0][3:0]         low_in;
  logic [THREADS-1:0][LINE_W-1:0]  line_q;
  logic [THREADS-1:0][OFF_W-1:0]   off_q;
  logic [THREADS-1:0]              pend_q;
  logic [THREADS-1:0]              serve;
  logic [THREADS-1:0]              pend_nxt;
  logic [2:0]                      size_q;
  logic                            store_q;
  logic                            err_q;
  logic [CNT_W-1:0]                cnt_q;
  logic [CNT_W-1:0]                cap;
  logic [LINE_W-1:0]               lead_line;
  logic                            bad;
  logic                            accept;
  logic                            fire;

  assign addr_in = req_addr_i;

  for (genvar g = 0; g < THREADS; g++) begin : g_split
    assign low_in[g] = addr_in[g][3:0];
    assign line_q[g] = addr_q[g][ADDR_W-1:OFF_W];
    assign off_q[g]  = addr_q[g][OFF_W-1:0];
  end

  coal_align_check #(.THREADS(THREADS)) u_align (
    .low_i  (low_in),
    .mask_i (req_mask_i),
    .size_i (req_size_i),
    .bad_o  (bad)
  );

  assign cap = (size_q == 3'(SZ_B16)) ? CNT_W'(WIDE_CAP) : CNT_W'(THREADS);

  coal_pick #(.THREADS(THREADS), .LINE_W(LINE_W)) u_pick (
    .pend_i      (pend_q),
    .line_i      (line_q),
    .cap_i       (cap),
    .lead_line_o (lead_line),
    .serve_o     (serve)
  );

  coal_byte_en #(.THREADS(THREADS), .LINE_BYTES(LINE_BYTES)) u_be (
    .serve_i (serve),
    .off_i   (off_q),
    .size_i  (size_q),
    .be_o    (txn_be_o)
  );

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign fire     = txn_valid_o && txn_ready_i;
  assign pend_nxt = pend_q & ~serve;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pend_q  <= '0;
      size_q  <= '0;
      store_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= addr_in;
          size_q  <= req_size_i;
          store_q <= req_store_i;
          cnt_q   <= '0;
          err_q   <= bad;
          if (bad || (req_mask_i == '0)) begin
            pend_q  <= '0;
            state_q <= ST_FIN;
          end else begin
            pend_q  <= req_mask_i;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (fire) begin
          pend_q <= pend_nxt;
          cnt_q  <= cnt_q + 1'b1;
          if (pend_nxt == '0) state_q <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign txn_valid_o  = (state_q == ST_RUN);
  assign txn_addr_o   = {lead_line, {OFF_W{1'b0}}};
  assign txn_store_o  = store_q;
  assign done_o       = (state_q == ST_FIN);
  assign done_count_o = cnt_q;
  assign done_err_o   = (state_q == ST_FIN) && err_q;
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int unsigned THREADS    = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned WIDE_CAP   = 16,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned CNT_W     = $clog2(THREADS + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_ready_o,
  input logic                  txn_valid_o,
  input logic                  txn_ready_i,
  input logic [ADDR_W-1:0]     txn_addr_o,
  input logic [LINE_BYTES-1:0] txn_be_o,
  input logic                  done_o,
  input logic [CNT_W-1:0]      done_count_o,
  input logic                  done_err_o,
  input logic [THREADS-1:0]    serve,
  input logic [2:0]            size_q
);
  AST_TXN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_addr_o) && $stable(txn_be_o)); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_o || done_o) |-> !req_ready_o); // R10
  AST_LINE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_addr_o[OFF_W-1:0] == '0) && (|txn_be_o)); // R2
  AST_WIDE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && (size_q == 3'd4) |-> ($countones(serve) <= WIDE_CAP)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o); // R12
  AST_ERR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_err_o |-> done_o && (done_count_o == '0)); // R8
  AST_COUNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_count_o <= CNT_W'(THREADS))); // R3
endmodule

bind warp_coalescer warp_coalescer_chk #(
  .THREADS(THREADS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WIDE_CAP(WIDE_CAP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .txn_valid_o  (txn_valid_o),
  .txn_ready_i  (txn_ready_i),
  .txn_addr_o   (txn_addr_o),
  .txn_be_o     (txn_be_o),
  .done_o       (done_o),
  .done_count_o (done_count_o),
  .done_err_o   (done_err_o),
  .serve        (serve),
  .size_q       (size_q)
);

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  localparam int NT = 32;
  localparam int AW = 32;
  localparam int LB = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [NT*AW-1:0] req_addr = '0;
  logic [NT-1:0]   req_mask = '0;
  logic [2:0]      req_size = '0;
  logic            req_store = 1'b0;
  logic            txn_valid;
  logic            txn_ready = 1'b0;
  logic [AW-1:0]   txn_addr;
  logic [LB-1:0]   txn_be;
  logic            txn_store;
  logic            done;
  logic [5:0]      done_count;
  logic            done_err;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [AW-1:0] t_addr [NT];
  logic [AW-1:0] e_addr [NT];
  logic [LB-1:0] e_be   [NT];
  int            e_n;
  bit            e_err;

  always #4 clk = ~clk;

  warp_coalescer u_warp_coalescer (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_mask_i(req_mask), .req_size_i(req_size),
    .req_store_i(req_store),
    .txn_valid_o(txn_valid), .txn_ready_i(txn_ready),
    .txn_addr_o(txn_addr), .txn_be_o(txn_be), .txn_store_o(txn_store),
    .done_o(done), .done_count_o(done_count), .done_err_o(done_err)
  );

  task automatic chk(input bit ok, input string rq, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  // expected transaction list from the requirements
  task automatic model(input logic [NT-1:0] mask, input logic [2:0] size);
    logic [NT-1:0] pend;
    int nb, cap, lead, taken;
    e_n = 0;
    e_err = (size > 3'd4);
    nb = 1 << size;
    if (!e_err)
      for (int i = 0; i < NT; i++)
        if (mask[i] && (t_addr[i] % nb != 0)) e_err = 1'b1;
    if (e_err) return;
    cap = (size == 3'd4) ? 16 : NT;
    pend = mask;
    while (pend != '0) begin
      lead = 0;
      for (int i = NT - 1; i >= 0; i--) if (pend[i]) lead = i;
      e_addr[e_n] = {t_addr[lead][AW-1:7], 7'd0};
      e_be[e_n] = '0;
      taken = 0;
      for (int i = 0; i < NT; i++) begin
        if (pend[i] && (t_addr[i][AW-1:7] == t_addr[lead][AW-1:7]) && taken < cap) begin
          for (int b = 0; b < nb; b++) e_be[e_n][int'(t_addr[i][6:0]) + b] = 1'b1;
          pend[i] = 1'b0;
          taken++;
        end
      end
      e_n++;
    end
  endtask

  task automatic run_req(input logic [NT-1:0] mask, input logic [2:0] size, input bit st,
                         input int bp, input string rq);
    int k;
    int guard;
    model(mask, size);
    @(negedge clk);
    chk(req_ready, "R10 ready idle", LB'(req_ready), LB'(1));
    for (int i = 0; i < NT; i++) req_addr[i*AW +: AW] = t_addr[i];
    req_mask = mask; req_size = size; req_store = st; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    guard = 0;
    while (!done && guard < 500) begin
      chk(!req_ready, "R10 busy", LB'(req_ready), LB'(0));
      if (txn_valid) begin
        txn_ready = (bp == 0) || ($urandom % 4 != 0);
        if (k < e_n) begin
          chk(txn_addr == e_addr[k], {rq, " R7 addr"}, LB'(txn_addr), LB'(e_addr[k]));
          chk(txn_be == e_be[k], {rq, " R2 be"}, txn_be, e_be[k]);
          chk(txn_store == st, "R12 store flag", LB'(txn_store), LB'(st));
        end else chk(1'b0, {rq, " R12 extra txn"}, LB'(k), LB'(e_n));
        if (txn_ready) k++;
      end
      @(negedge clk);
      txn_ready = 1'b0;
      guard++;
    end
    chk(done, {rq, " R12 done seen"}, LB'(done), LB'(1));
    chk(!req_ready, "R10 ready low at done", LB'(req_ready), LB'(0));
    chk(int'(done_count) == e_n && k == e_n, {rq, " R12 count"}, LB'(done_count), LB'(e_n));
    chk(done_err == e_err, {rq, " R8 err"}, LB'(done_err), LB'(e_err));
    @(negedge clk);
    chk(!done && req_ready, "R12 done one cycle", LB'(done), LB'(0));
  endtask

  initial begin
    logic [NT-1:0] m;
    logic [2:0] sz;
    void'($urandom(32'h5eed_c0a1));
    #3;
    chk(req_ready && !txn_valid && !done, "R1 reset state", LB'({req_ready, txn_valid, done}), LB'(3'b100));
    #20 rst_n = 1'b1;

    // R5: full warp, 16B, same address -> 2 txns
    for (int i = 0; i < NT; i++) t_addr[i] = 32'h0000_1040;
    run_req('1, 3'd4, 1'b1, 1, "R5 same16");
    chk(e_n == 2, "R5 expect two", LB'(e_n), LB'(2));

    // R4: sequential 16B -> 4 lines; same address 4B -> 1 txn
    for (int i = 0; i < NT; i++) t_addr[i] = 32'h0002_0000 + 16 * i;
    run_req('1, 3'd4, 1'b0, 1, "R4 seq16");
    for (int i = 0; i < NT; i++) t_addr[i] = 32'h0000_3008;
    run_req('1, 3'd2, 1'b0, 0, "R4 same4");
    chk(e_n == 1, "R4 expect one", LB'(e_n), LB'(1));

    // R3: distinct lines, partial mask
    for (int i = 0; i < NT; i++) t_addr[i] = 32'h0010_0000 + 128 * (NT - i) + 4;
    m = 32'hA5F0_0F13;
    run_req(m, 3'd2, 1'b1, 1, "R3 distinct");
    chk(e_n == $countones(m), "R3 count=active", LB'(e_n), LB'($countones(m)));

    // R7/R5: overflow of a crowded line interleaved with other lines
    for (int i = 0; i < NT; i++) t_addr[i] = (i % 3 == 1) ? 32'h0000_5000 + 16 * (i % 8) : 32'h0000_4000;
    run_req('1, 3'd4, 1'b0, 1, "R7 mixed");

    // R8: misaligned active thread; bad size code
    for (int i = 0; i < NT; i++) t_addr[i] = 32'h0000_6000 + 4 * i;
    t_addr[9] = 32'h0000_6026;
    run_req('1, 3'd2, 1'b0, 1, "R8 misalign");
    run_req('1, 3'd6, 1'b0, 1, "R8 badsize");
    // R6: same misaligned thread masked off -> no error, its bytes absent
    run_req(~(32'd1 << 9), 3'd2, 1'b0, 1, "R6 masked");
    chk(!e_err, "R6 no error expected", LB'(e_err), LB'(0));

    // R9: empty mask
    run_req('0, 3'd2, 1'b0, 1, "R9 empty");

    // random, few lines so lines crowd
    for (int r = 0; r < 60; r++) begin
      sz = 3'($urandom % 5);
      for (int i = 0; i < NT; i++) begin
        t_addr[i] = 32'h0008_0000 + 128 * ($urandom % 3) + ($urandom % 128);
        t_addr[i] = t_addr[i] & ~((32'd1 << sz) - 1);
      end
      m = (r % 4 == 0) ? '1 : 32'($urandom);
      run_req(m, sz, 1'($urandom), 1, "R4 random");
    end
    finish_run();
  end
endmodule